// File: doc/BRIEF.md
# Transmit Sample Queue with APB3 Control

This block sits between a processor bus and a transmit converter path. Software writes packed IQ sample words through an APB3 slave port into a small FIFO. A pacing counter then takes one word out of the FIFO every N clock cycles, where N is set by the interpolation register. Each word taken out appears for one cycle on a strobed output that stands in for the converter-side consumer.

The register set holds a control/status word, a pair of 16-bit threshold values, the interpolation period, and a runs word. The runs word keeps two separate counts. Overruns (sample writes that found the FIFO full) sit in the lower half. Underruns (pacing instants that found the FIFO empty while transmit was running) sit in the upper half. A clear command empties the queue and zeroes both counts without touching the other settings.

Register offsets (byte addresses): control/status 0x00, threshold 0x04, interpolation 0x08, runs 0x0C, sample 0x10.

Top module: `txq_apb_ctrl`

## Requirements
- R1: The slave answers every transfer with no wait states. `pready` is always 1 and `pslverr` is always 0. A write takes effect at the clock edge that ends its access phase. Read data is valid during the access phase.
- R2: The threshold register at 0x04 reads back all 32 bits exactly as written. The interpolation register at 0x08 reads back the written value in its low INTERP_W bits, with zeros above.
- R3: While transmit is enabled with interpolation value N (0 acts as 1), one word is consumed every N cycles. The first consume happens at the Nth rising edge after the edge that enables transmit. Each consume of a stored word raises `smp_valid` for exactly one cycle, starting at that edge. During that cycle `smp_i` carries word bits 31:16 and `smp_q` carries bits 15:0. Words leave in the order they were written.
- R4: A write to the sample register at 0x10 while the FIFO is full discards the word and adds one to runs bits 15:0.
- R5: A pacing instant that finds the FIFO empty while transmit is enabled adds one to runs bits 31:16 and produces no `smp_valid`.
- R6: Status bit 4 (space) reads 1 exactly when the FIFO is not full. Status bit 5 (data) reads 1 exactly when it is not empty.
- R7: Writing the status register with bit 3 set (clear) empties the FIFO and sets both run counts to zero. Afterwards space reads 1 and data reads 0.
- R8: Status bit 0 (transmit enable) and bit 2 (loopback) read back as written, and `loop_mode` follows bit 2. A status write with bit 1 (stop) set leaves transmit disabled whatever bit 0 holds. While transmit is disabled, no consume happens and the underrun count holds still.
- R9: After reset, threshold and runs read 0, interpolation reads 1, and status reads 0x10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and block clock |
| presetn | input | 1 | Active-low asynchronous reset |
| paddr | input | ADDR_W | Byte address of the transfer |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 for write, 0 for read |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Transfer complete, always 1 |
| pslverr | output | 1 | Error response, always 0 |
| smp_valid | output | 1 | One-cycle strobe for a consumed word |
| smp_i | output | 16 | In-phase half of the consumed word |
| smp_q | output | 16 | Quadrature half of the consumed word |
| loop_mode | output | 1 | Loopback enable bit |

## Verification
The bench fills the queue to the brim and keeps writing. A design that stored a word while full, or that did not count the discard, would show a wrong overrun half or an extra word in the output stream. It times every strobe against the enabling edge at interpolation 3 and at 0. An off-by-one pacing counter would place strobes a cycle early or late, and a design that treated 0 literally would stall. After the queue drains, the bench checks that underruns accumulate only while enabled and freeze after a stop. It then checks that clear zeroes both halves of the runs word and restores the space and data flags, which would catch a clear that left a stale pointer or count.

// File: rtl/txq_pkg.sv
package txq_pkg;
  // register byte offsets
  localparam logic [4:0] OFF_STAT   = 5'h00;
  localparam logic [4:0] OFF_THRESH = 5'h04;
  localparam logic [4:0] OFF_INTERP = 5'h08;
  localparam logic [4:0] OFF_RUNS   = 5'h0C;
  localparam logic [4:0] OFF_SAMPLE = 5'h10;
  // status bit positions
  localparam int B_EN    = 0;
  localparam int B_STOP  = 1;
  localparam int B_LOOP  = 2;
  localparam int B_CLR   = 3;
  localparam int B_SPACE = 4;
  localparam int B_DATA  = 5;

  // runs word: underruns high, overruns low
  function automatic logic [31:0] runs_word(input logic [15:0] ovr, input logic [15:0] und);
    return {und, ovr};
  endfunction

  // interpolation value 0 behaves as 1
  function automatic logic [15:0] pace_len(input logic [15:0] val);
    return (val == 16'd0) ? 16'd1 : val;
  endfunction
endpackage

// File: rtl/txq_fifo.sv
module txq_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push && !full) wr_ptr <= bump(wr_ptr);
      if (pop && !empty) rd_ptr <= bump(rd_ptr);
      case ({push && !full, pop && !empty})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/txq_pacer.sv
module txq_pacer #(
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [IW-1:0] len,
  output logic          tick
);
  import txq_pkg::*;

  logic [IW-1:0] cnt;
  logic [15:0]   len_eff;

  assign len_eff = pace_len(16'(len));
  assign tick    = run && ({16'd0, cnt} >= {16'd0, len_eff} - 32'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/txq_apb_ctrl.sv
module txq_apb_ctrl #(
  parameter int ADDR_W   = 5,
  parameter int DEPTH    = 16,
  parameter int INTERP_W = 16
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic [ADDR_W-1:0] paddr,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  output logic              smp_valid,
  output logic [15:0]       smp_i,
  output logic [15:0]       smp_q,
  output logic              loop_mode
);
  import txq_pkg::*;

  localparam int HALF = 16;

  logic [4:0]          reg_off;
  logic                bus_wr, bus_rd;
  logic                tx_en, loop_en;
  logic [31:0]         thresh;
  logic [INTERP_W-1:0] interp;
  logic [HALF-1:0]     ovr_cnt, und_cnt;
  logic                fifo_full, fifo_empty;
  logic [31:0]         fifo_head;
  logic                tick;

  // named internal events (observed by the checker)
  logic ev_clr, ev_wsmp, ev_push, ev_ovr, ev_pop, ev_und;

  assign reg_off = 5'(paddr);
  assign bus_wr  = psel && penable && pwrite;
  assign bus_rd  = psel && !pwrite;
  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  assign ev_clr  = bus_wr && (reg_off == OFF_STAT) && pwdata[B_CLR];
  assign ev_wsmp = bus_wr && (reg_off == OFF_SAMPLE);
  assign ev_push = ev_wsmp && !fifo_full;
  assign ev_ovr  = ev_wsmp && fifo_full;
  assign ev_pop  = tick && !fifo_empty;
  assign ev_und  = tick && fifo_empty;

  txq_fifo #(.W(32), .DEPTH(DEPTH)) u_fifo (
    .clk   (pclk),
    .rst_n (presetn),
    .flush (ev_clr),
    .push  (ev_push),
    .pop   (ev_pop),
    .din   (pwdata),
    .dout  (fifo_head),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  txq_pacer #(.IW(INTERP_W)) u_pacer (
    .clk   (pclk),
    .rst_n (presetn),
    .run   (tx_en),
    .len   (interp),
    .tick  (tick)
  );

  // configuration registers
  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      tx_en   <= 1'b0;
      loop_en <= 1'b0;
      thresh  <= '0;
      interp  <= INTERP_W'(1);
    end else if (bus_wr) begin
      case (reg_off)
        OFF_STAT: begin
          tx_en   <= pwdata[B_EN] && !pwdata[B_STOP];
          loop_en <= pwdata[B_LOOP];
        end
        OFF_THRESH: thresh <= pwdata;
        OFF_INTERP: interp <= pwdata[INTERP_W-1:0];
        default: ;
      endcase
    end
  end

  // run counters
  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      ovr_cnt <= '0;
      und_cnt <= '0;
    end else if (ev_clr) begin
      ovr_cnt <= '0;
      und_cnt <= '0;
    end else begin
      if (ev_ovr) ovr_cnt <= ovr_cnt + 1'b1;
      if (ev_und) und_cnt <= und_cnt + 1'b1;
    end
  end

  // consumer-side output
  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      smp_valid <= 1'b0;
      smp_i     <= '0;
      smp_q     <= '0;
    end else begin
      smp_valid <= ev_pop;
      if (ev_pop) begin
        smp_i <= fifo_head[31:16];
        smp_q <= fifo_head[15:0];
      end
    end
  end

  assign loop_mode = loop_en;

  // read mux
  always_comb begin
    prdata = '0;
    if (bus_rd) begin
      case (reg_off)
        OFF_STAT: begin
          prdata[B_EN]    = tx_en;
          prdata[B_LOOP]  = loop_en;
          prdata[B_SPACE] = !fifo_full;
          prdata[B_DATA]  = !fifo_empty;
        end
        OFF_THRESH: prdata = thresh;
        OFF_INTERP: prdata = 32'(interp);
        OFF_RUNS:   prdata = runs_word(ovr_cnt, und_cnt);
        default:    prdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/txq_chk.sv
module txq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pready,
  input logic        pslverr,
  input logic        ev_ovr,
  input logic        ev_push,
  input logic        ev_und,
  input logic        ev_pop,
  input logic        ev_clr,
  input logic        fifo_full,
  input logic        fifo_empty,
  input logic [15:0] ovr_cnt,
  input logic [15:0] und_cnt,
  input logic        smp_valid
);
  AST_ZERO_WAIT: assert property (@(posedge clk) disable iff (!rst_n) pready && !pslverr); // R1
  AST_STROBE_FROM_POP: assert property (@(posedge clk) disable iff (!rst_n) smp_valid |-> $past(ev_pop)); // R3
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) ev_pop && !fifo_empty |=> smp_valid); // R3
  AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n) fifo_full |-> !ev_push); // R4
  AST_OVR_COUNTS: assert property (@(posedge clk) disable iff (!rst_n) ev_ovr && !ev_clr |=> ovr_cnt == $past(ovr_cnt) + 16'd1); // R4
  AST_UND_COUNTS: assert property (@(posedge clk) disable iff (!rst_n) ev_und && !ev_clr |=> und_cnt == $past(und_cnt) + 16'd1); // R5
  AST_UND_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n) ev_und |=> !smp_valid); // R5
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(fifo_full && fifo_empty)); // R6
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) ev_clr |=> fifo_empty && ovr_cnt == 16'd0 && und_cnt == 16'd0); // R7
endmodule

bind txq_apb_ctrl txq_chk u_chk (
  .clk        (pclk),
  .rst_n      (presetn),
  .pready     (pready),
  .pslverr    (pslverr),
  .ev_ovr     (ev_ovr),
  .ev_push    (ev_push),
  .ev_und     (ev_und),
  .ev_pop     (ev_pop),
  .ev_clr     (ev_clr),
  .fifo_full  (fifo_full),
  .fifo_empty (fifo_empty),
  .ovr_cnt    (ovr_cnt),
  .und_cnt    (und_cnt),
  .smp_valid  (smp_valid)
);

// File: tb/test_txq_apb_ctrl.sv
module test_txq_apb_ctrl;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  paddr = '0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr, smp_valid, loop_mode;
  logic [15:0] smp_i, smp_q;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  txq_apb_ctrl #(.ADDR_W(5), .DEPTH(DEPTH), .INTERP_W(16)) i_txq_apb_ctrl (
    .pclk(clk), .presetn(rst_n), .paddr(paddr), .psel(psel), .penable(penable),
    .pwrite(pwrite), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .smp_valid(smp_valid), .smp_i(smp_i), .smp_q(smp_q),
    .loop_mode(loop_mode)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [15:0] tag;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h04, 32'h0,        32'h0,        "R9"},
    '{1'b0, 8'h08, 32'h0,        32'h1,        "R9"},
    '{1'b0, 8'h0C, 32'h0,        32'h0,        "R9"},
    '{1'b0, 8'h00, 32'h0,        32'h10,       "R9"},
    '{1'b1, 8'h04, 32'h00010003, 32'h0,        "R2"},
    '{1'b0, 8'h04, 32'h0,        32'h00010003, "R2"},
    '{1'b1, 8'h04, 32'hFFFFFFFF, 32'h0,        "R2"},
    '{1'b0, 8'h04, 32'h0,        32'hFFFFFFFF, "R2"},
    '{1'b1, 8'h08, 32'h000100C8, 32'h0,        "R2"},
    '{1'b0, 8'h08, 32'h0,        32'h000000C8, "R2"},
    '{1'b1, 8'h00, 32'h00000005, 32'h0,        "R8"},
    '{1'b0, 8'h00, 32'h0,        32'h00000015, "R8"},
    '{1'b1, 8'h00, 32'h00000007, 32'h0,        "R8"},
    '{1'b0, 8'h00, 32'h0,        32'h00000014, "R8"}
  };

  task automatic check(input logic [15:0] tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apb_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(posedge clk);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    #5 d = prdata;
    @(posedge clk);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  function automatic logic [31:0] word_of(input int k);
    return {16'(k + 1) * 16'h1111, 16'hF000 + 16'(k)};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] rd, r1, r2;
    int k, idx;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R9 reset state of outputs
    @(negedge clk);
    check("R9", {31'd0, smp_valid}, 32'd0);
    check("R1", {30'd0, pready, pslverr}, 32'h2);

    // vector table
    for (int v = 0; v < NV; v++) begin
      if (VEC[v].wr) apb_write(VEC[v].addr[4:0], VEC[v].data);
      else begin
        apb_read(VEC[v].addr[4:0], rd);
        check(VEC[v].tag, rd, VEC[v].exp);
      end
    end
    check("R8", {31'd0, loop_mode}, 32'd1);

    // R7 clear
    apb_write(5'h00, 32'h8);
    apb_read(5'h0C, rd); check("R7", rd, 32'h0);
    apb_read(5'h00, rd); check("R7", rd, 32'h10);
    check("R8", {31'd0, loop_mode}, 32'd0);

    // fill: R6 flags
    apb_write(5'h10, word_of(0));
    apb_read(5'h00, rd); check("R6", rd, 32'h30);
    for (int j = 1; j < DEPTH; j++) apb_write(5'h10, word_of(j));
    apb_read(5'h00, rd); check("R6", rd, 32'h20);

    // R4 overrun discards
    apb_write(5'h10, 32'hDEAD0001);
    apb_write(5'h10, 32'hDEAD0002);
    apb_read(5'h0C, rd); check("R4", rd, 32'h00000002);

    // R3 pacing at interpolation 3
    apb_write(5'h08, 32'd3);
    apb_write(5'h00, 32'h1);
    k = 0; idx = 0;
    repeat (40) begin
      @(negedge clk);
      k++;
      if (smp_valid) begin
        check("R3", k, 3 * (idx + 1));
        check("R3", {smp_i, smp_q}, word_of(idx));
        idx++;
      end
    end
    check("R3", idx, DEPTH);

    // R5 underruns accumulated, overruns untouched
    apb_read(5'h0C, rd);
    check("R5", {31'd0, rd[31:16] != 16'd0}, 32'd1);
    check("R4", {16'd0, rd[15:0]}, 32'd2);

    // R8 stop freezes underruns
    apb_write(5'h00, 32'h3);
    apb_read(5'h0C, r1);
    repeat (20) @(negedge clk);
    apb_read(5'h0C, r2);
    check("R8", r2, r1);
    apb_read(5'h00, rd); check("R8", rd, 32'h10);

    // R7 clear after runs
    apb_write(5'h00, 32'h8);
    apb_read(5'h0C, rd); check("R7", rd, 32'h0);

    // R3 interpolation 0 acts as 1
    apb_write(5'h08, 32'd0);
    apb_read(5'h08, rd); check("R2", rd, 32'h0);
    apb_write(5'h10, word_of(5));
    apb_write(5'h10, word_of(6));
    apb_write(5'h00, 32'h1);
    k = 0; idx = 0;
    repeat (4) begin
      @(negedge clk);
      k++;
      if (smp_valid) begin
        check("R3", k, idx + 1);
        check("R3", {smp_i, smp_q}, word_of(5 + idx));
        idx++;
      end
    end
    check("R3", idx, 2);
    apb_write(5'h00, 32'h2);

    finish_run();
  end
endmodule